// File: doc/BRIEF.md
# Touch Button Output and Interrupt Controller

This block sits between a periodic capacitive sensing engine and the outside world. Once per scan period it takes the engine's per-channel "button detected" decisions and drives one output pin per button, plus a shared interrupt pin. The scan period is derived from the clock frequency and a scan rate parameter. The default is 40 scans per second, which gives a 25 ms period. A single sampling window sits at the start of each period. All button pins move together on the clock edge that closes that window, and they never move mid-period.

A small status word is readable by a host through a read strobe and an address. The word holds a sticky "a button went down" flag, a sticky "sampling pass complete" flag and one sticky bit per error source. Reading address 0 returns the word and clears those bits. A set event in the same cycle takes precedence over the clear. Error events always raise the interrupt. In raw-data mode the button pins are held inactive, and the interrupt instead reports that a sampling pass has finished. The polarity of the button pins and of the interrupt pin can each be selected.

Top module: `touch_out_ctrl`

## Requirements
- R1: The sampling window closes on exactly one clock edge every SCAN_TICKS = CLK_HZ/SCAN_HZ cycles. Counting from reset release with the first edge as 0, it closes on the edge whose index within the period is SCAN_TICKS/WIN_DIV-1, and `btnDetect` is sampled only on that edge.
- R2: Outside the window-closing edge, `btnOut` does not change in response to `btnDetect`.
- R3: In normal mode the interrupt is active whenever at least one button output is active or any error bit is set. Otherwise it is inactive.
- R4: When one button is released and another is pressed within the same period, the first output drops and the second rises on the same window-closing edge.
- R5: Status bit 0 is set on a window-closing edge where some button goes from released to pressed. It is not set again by buttons that were already pressed.
- R6: A read strobe with address 0 clears status bits 0, 1 and all error bits. If a set event occurs in the same cycle, the bit stays set.
- R7: `outActiveLow` = 1 inverts every button pin, and `intActiveLow` = 1 inverts the interrupt pin. An inactive level is then high.
- R8: A pulse on `errEvent[i]` sets status bit 2+i, which stays set until read. It also makes the interrupt active from the next cycle onward.
- R9: With `rawMode` = 1 the button pins are inactive. Each window-closing edge sets status bit 1, and the interrupt is active while bit 1 or any error bit is set.
- R10: A read at any nonzero address returns zero and clears nothing. After reset all pins are inactive and the status word is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| btnDetect | input | NUM_BTN | Per-channel detect decision from the sensing engine |
| errEvent | input | NUM_ERR | Error event pulses, one per error source |
| rawMode | input | 1 | 1 selects raw-data mode |
| outActiveLow | input | 1 | 1 makes button pins active low |
| intActiveLow | input | 1 | 1 makes the interrupt pin active low |
| rdStrobe | input | 1 | Host read strobe, one cycle per read |
| rdAddr | input | ADDR_W | Host read address; 0 is the status word |
| rdData | output | NUM_ERR+2 | Status word when address is 0, else zero |
| btnOut | output | NUM_BTN | Button output pins |
| intOut | output | 1 | Shared interrupt pin |

## Verification
The assertions assume that `rawMode` and `outActiveLow` change only as static configuration. A change in either is the one thing allowed to move `btnOut` away from a window-closing edge. They also assume that a read strobe lasts one cycle, with its address steady in that cycle. The stimulus changes mode and polarity only at negative clock edges, and it checks right afterwards. Reads are issued as single-cycle strobes. Error events are single-cycle pulses. Collisions between a read and a set event are placed on purpose on the window-closing edge or on the error pulse cycle.

// File: rtl/tbo_pkg.sv
`timescale 1ns/1ps
package tbo_pkg;
  // Strobes passed from control to datapath each cycle
  typedef struct packed {
    logic sample;   // window close in normal mode: capture detects
    logic rawPass;  // window close in raw mode: pass complete
    logic rdClear;  // host read of the status word
    logic addrHit;  // read address selects the status word
  } ctlStrb_t;
endpackage

// File: rtl/tbo_scan_timer.sv
`timescale 1ns/1ps
module tbo_scan_timer #(
  parameter int SCAN_TICKS = 25000,
  parameter int WIN_END    = 6249
) (
  input  logic clk,
  input  logic rst,
  output logic winEnd
);
  localparam int CNT_W = (SCAN_TICKS > 1) ? $clog2(SCAN_TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SCAN_TICKS - 1);
  localparam logic [CNT_W-1:0] WEND = CNT_W'(WIN_END);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign winEnd = (cnt == WEND);
endmodule

// File: rtl/tbo_ctrl.sv
`timescale 1ns/1ps
module tbo_ctrl
  import tbo_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              winEnd,
  input  logic              rawMode,
  input  logic              rdStrobe,
  input  logic [ADDR_W-1:0] rdAddr,
  output ctlStrb_t          strb
);
  localparam logic [ADDR_W-1:0] STATUS_ADDR = '0;

  always_comb begin
    strb.sample  = winEnd && !rawMode;
    strb.rawPass = winEnd && rawMode;
    strb.addrHit = (rdAddr == STATUS_ADDR);
    strb.rdClear = rdStrobe && (rdAddr == STATUS_ADDR);
  end
endmodule

// File: rtl/tbo_datapath.sv
`timescale 1ns/1ps
module tbo_datapath
  import tbo_pkg::*;
#(
  parameter int NUM_BTN = 4,
  parameter int NUM_ERR = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  ctlStrb_t           strb,
  input  logic [NUM_BTN-1:0] btnDetect,
  input  logic [NUM_ERR-1:0] errEvent,
  input  logic               rawMode,
  input  logic               outActiveLow,
  input  logic               intActiveLow,
  output logic [NUM_BTN-1:0] btnOut,
  output logic               intOut,
  output logic [NUM_ERR+1:0] statusWord,
  output logic [NUM_ERR+1:0] rdData
);
  localparam int STAT_W = NUM_ERR + 2;

  logic [NUM_BTN-1:0] btnState;
  logic               outFlag;
  logic               readyFlag;
  logic [NUM_ERR-1:0] errFlags;
  logic               newPress;
  logic               intLevel;

  // Button state: captured only when a window closes
  always_ff @(posedge clk) begin
    if (rst)               btnState <= '0;
    else if (strb.rawPass) btnState <= '0;
    else if (strb.sample)  btnState <= btnDetect;
  end

  assign newPress = strb.sample && ((btnDetect & ~btnState) != '0);

  // Sticky flags: a set event beats a clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst)               outFlag <= 1'b0;
    else if (newPress)     outFlag <= 1'b1;
    else if (strb.rdClear) outFlag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)               readyFlag <= 1'b0;
    else if (strb.rawPass) readyFlag <= 1'b1;
    else if (strb.rdClear) readyFlag <= 1'b0;
  end

  for (genvar e = 0; e < NUM_ERR; e++) begin : g_err
    always_ff @(posedge clk) begin
      if (rst)               errFlags[e] <= 1'b0;
      else if (errEvent[e])  errFlags[e] <= 1'b1;
      else if (strb.rdClear) errFlags[e] <= 1'b0;
    end
  end

  always_comb begin
    if (rawMode) intLevel = readyFlag || (errFlags != '0);
    else         intLevel = (btnState != '0) || (errFlags != '0);
  end

  assign btnOut     = (rawMode ? '0 : btnState) ^ {NUM_BTN{outActiveLow}};
  assign intOut     = intLevel ^ intActiveLow;
  assign statusWord = {errFlags, readyFlag, outFlag};
  assign rdData     = strb.addrHit ? statusWord : {STAT_W{1'b0}};
endmodule

// File: rtl/touch_out_ctrl.sv
`timescale 1ns/1ps
module touch_out_ctrl
  import tbo_pkg::*;
#(
  parameter int NUM_BTN = 4,
  parameter int NUM_ERR = 2,
  parameter int ADDR_W  = 4,
  parameter int CLK_HZ  = 1000000,
  parameter int SCAN_HZ = 40,
  parameter int WIN_DIV = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_BTN-1:0] btnDetect,
  input  logic [NUM_ERR-1:0] errEvent,
  input  logic               rawMode,
  input  logic               outActiveLow,
  input  logic               intActiveLow,
  input  logic               rdStrobe,
  input  logic [ADDR_W-1:0]  rdAddr,
  output logic [NUM_ERR+1:0] rdData,
  output logic [NUM_BTN-1:0] btnOut,
  output logic               intOut
);
  localparam int SCAN_TICKS = CLK_HZ / SCAN_HZ;
  localparam int WIN_END    = SCAN_TICKS / WIN_DIV - 1;

  logic               winEnd;
  ctlStrb_t           strb;
  logic [NUM_ERR+1:0] statusWord;

  tbo_scan_timer #(.SCAN_TICKS(SCAN_TICKS), .WIN_END(WIN_END)) i_timer (
    .clk(clk), .rst(rst), .winEnd(winEnd)
  );

  tbo_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .winEnd(winEnd), .rawMode(rawMode), .rdStrobe(rdStrobe),
    .rdAddr(rdAddr), .strb(strb)
  );

  tbo_datapath #(.NUM_BTN(NUM_BTN), .NUM_ERR(NUM_ERR)) i_dp (
    .clk(clk), .rst(rst), .strb(strb), .btnDetect(btnDetect),
    .errEvent(errEvent), .rawMode(rawMode), .outActiveLow(outActiveLow),
    .intActiveLow(intActiveLow), .btnOut(btnOut), .intOut(intOut),
    .statusWord(statusWord), .rdData(rdData)
  );
endmodule

// File: rtl/tbo_checker.sv
`timescale 1ns/1ps
module tbo_checker #(
  parameter int NUM_BTN    = 4,
  parameter int NUM_ERR    = 2,
  parameter int ADDR_W     = 4,
  parameter int SCAN_TICKS = 25000
) (
  input logic               clk,
  input logic               rst,
  input logic               winEnd,
  input logic               rawMode,
  input logic               outActiveLow,
  input logic               intActiveLow,
  input logic [NUM_BTN-1:0] btnOut,
  input logic               intOut,
  input logic [NUM_ERR-1:0] errEvent,
  input logic               rdStrobe,
  input logic [ADDR_W-1:0]  rdAddr,
  input logic [NUM_ERR+1:0] statusWord
);
  logic [31:0] gapCnt;
  logic        seenWin;

  always_ff @(posedge clk) begin
    if (rst) begin
      gapCnt  <= '0;
      seenWin <= 1'b0;
    end else if (winEnd) begin
      gapCnt  <= '0;
      seenWin <= 1'b1;
    end else begin
      gapCnt  <= gapCnt + 1;
    end
  end

  // R1
  win_period_chk: assert property (@(posedge clk) disable iff (rst)
    (winEnd && seenWin) |-> (gapCnt == 32'(SCAN_TICKS - 1)));

  // R2
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !winEnd |=> ($stable(btnOut) || !$stable(rawMode) || !$stable(outActiveLow)));

  // R3
  int_follows_btn_chk: assert property (@(posedge clk) disable iff (rst)
    (!rawMode && ((btnOut ^ {NUM_BTN{outActiveLow}}) != '0)) |-> (intOut != intActiveLow));

  // R8
  err_raises_int_chk: assert property (@(posedge clk) disable iff (rst)
    ((errEvent != '0) && $stable(intActiveLow)) |=> (intOut != intActiveLow));

  // R9
  raw_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    rawMode |-> (btnOut == {NUM_BTN{outActiveLow}}));

  // R6
  read_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rdStrobe && (rdAddr == '0) && !winEnd && (errEvent == '0)) |=> (statusWord == '0));

  // R10
  sticky_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !(rdStrobe && (rdAddr == '0)) |=> ((statusWord & $past(statusWord)) == $past(statusWord)));
endmodule

bind touch_out_ctrl tbo_checker #(
  .NUM_BTN(NUM_BTN), .NUM_ERR(NUM_ERR), .ADDR_W(ADDR_W), .SCAN_TICKS(SCAN_TICKS)
) i_chk (
  .clk(clk), .rst(rst), .winEnd(winEnd), .rawMode(rawMode),
  .outActiveLow(outActiveLow), .intActiveLow(intActiveLow), .btnOut(btnOut),
  .intOut(intOut), .errEvent(errEvent), .rdStrobe(rdStrobe), .rdAddr(rdAddr),
  .statusWord(statusWord)
);

// File: tb/test_touch_out_ctrl.sv
`timescale 1ns/1ps
module test_touch_out_ctrl;
  localparam int NB = 4;
  localparam int NE = 2;
  localparam int AW = 4;
  localparam int PERIOD = 20;   // 800 / 40
  localparam int WPH = 4;       // 20/4 - 1

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NB-1:0] btnDetect = '0;
  logic [NE-1:0] errEvent = '0;
  logic          rawMode = 1'b0;
  logic          outActiveLow = 1'b0;
  logic          intActiveLow = 1'b0;
  logic          rdStrobe = 1'b0;
  logic [AW-1:0] rdAddr = '0;
  logic [NE+1:0] rdData;
  logic [NB-1:0] btnOut;
  logic          intOut;

  int total = 0;
  int bad = 0;
  int phase = 0;
  int cycles = 0;
  logic [NE+1:0] got;

  touch_out_ctrl #(.NUM_BTN(NB), .NUM_ERR(NE), .ADDR_W(AW), .CLK_HZ(800),
                   .SCAN_HZ(40), .WIN_DIV(4)) i_touch_out_ctrl (
    .clk(clk), .rst(rst), .btnDetect(btnDetect), .errEvent(errEvent),
    .rawMode(rawMode), .outActiveLow(outActiveLow), .intActiveLow(intActiveLow),
    .rdStrobe(rdStrobe), .rdAddr(rdAddr), .rdData(rdData), .btnOut(btnOut),
    .intOut(intOut)
  );

  always #2.5 clk = ~clk;

  // Period position from the R1 rule, counted from reset release
  always @(posedge clk) begin
    if (rst) phase <= 0;
    else     phase <= (phase == PERIOD - 1) ? 0 : phase + 1;
  end

  // {btnIn[3:0], expInt, expStatusBit0}
  localparam logic [5:0] VEC [0:7] = '{
    6'b0001_1_1, 6'b0011_1_1, 6'b0010_1_0, 6'b0100_1_1,
    6'b0000_0_0, 6'b1000_1_1, 6'b1000_1_0, 6'b0000_0_0
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Leaves us at the negedge just before a window-closing edge
  task automatic toWin();
    @(negedge clk);
    while (phase != WPH) @(negedge clk);
  endtask

  task automatic readAt(input logic [AW-1:0] a, output logic [NE+1:0] d);
    rdStrobe = 1'b1;
    rdAddr   = a;
    #1 d = rdData;
    @(negedge clk);
    rdStrobe = 1'b0;
    rdAddr   = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    chk("R10 reset btnOut", 32'(btnOut), 0);
    chk("R10 reset intOut", 32'(intOut), 0);
    readAt('0, got);
    chk("R10 reset status", 32'(got), 0);

    // Table walk: R3 R4 R5
    for (int k = 0; k < 8; k++) begin
      toWin();
      btnDetect = VEC[k][5:2];
      @(negedge clk);
      chk("R4 btnOut at window", 32'(btnOut), 32'(VEC[k][5:2]));
      chk("R3 intOut", 32'(intOut), 32'(VEC[k][1]));
      readAt('0, got);
      chk("R5 status bit0", 32'(got[0]), 32'(VEC[k][0]));
    end

    // R2: change mid-period has no effect until the window closes
    @(negedge clk);
    @(negedge clk);
    btnDetect = 4'b1111;
    repeat (3) @(negedge clk);
    chk("R2 mid-period hold", 32'(btnOut), 0);
    toWin();
    @(negedge clk);
    chk("R2 update at window", 32'(btnOut), 32'hF);
    // R1: released just after the window, held a full period
    btnDetect = 4'b0000;
    @(negedge clk);
    while (phase != WPH) @(negedge clk);
    chk("R1 held until window edge", 32'(btnOut), 32'hF);
    @(negedge clk);
    chk("R1 changed at window edge", 32'(btnOut), 0);
    readAt('0, got);
    chk("R5 status after 1111", 32'(got), 1);

    // R7 polarity
    outActiveLow = 1'b1;
    intActiveLow = 1'b1;
    #1;
    chk("R7 btnOut inactive low", 32'(btnOut), 32'hF);
    chk("R7 intOut inactive low", 32'(intOut), 1);
    @(negedge clk);
    outActiveLow = 1'b0;
    intActiveLow = 1'b0;

    // R8 error sticky and interrupt
    errEvent = 2'b01;
    @(negedge clk);
    errEvent = 2'b00;
    chk("R8 int on error", 32'(intOut), 1);
    repeat (2) @(negedge clk);
    chk("R8 int held", 32'(intOut), 1);
    // R10 nonzero address reads zero, clears nothing
    readAt(4'd3, got);
    chk("R10 other addr", 32'(got), 0);
    readAt('0, got);
    chk("R8 error bit", 32'(got), 32'b000100);
    chk("R8 int cleared", 32'(intOut), 0);

    // R6 error set beats same-cycle read clear
    errEvent = 2'b10;
    readAt('0, got);
    errEvent = 2'b00;
    chk("R6 read before set", 32'(got), 0);
    readAt('0, got);
    chk("R6 set wins", 32'(got), 32'b001000);
    readAt('0, got);
    chk("R6 cleared", 32'(got), 0);

    // R6 button press on the same edge as a read
    toWin();
    btnDetect = 4'b0100;
    readAt('0, got);
    readAt('0, got);
    chk("R6 press beats read", 32'(got), 1);
    toWin();
    btnDetect = 4'b0000;
    @(negedge clk);
    readAt('0, got);

    // R9 raw mode
    rawMode = 1'b1;
    btnDetect = 4'b1111;
    #1;
    chk("R9 raw pins inactive", 32'(btnOut), 0);
    chk("R9 raw int idle", 32'(intOut), 0);
    toWin();
    @(negedge clk);
    chk("R9 raw pins after window", 32'(btnOut), 0);
    chk("R9 pass int", 32'(intOut), 1);
    readAt('0, got);
    chk("R9 ready bit", 32'(got), 32'b000010);
    chk("R9 int cleared", 32'(intOut), 0);
    errEvent = 2'b01;
    @(negedge clk);
    errEvent = 2'b00;
    chk("R9 error in raw", 32'(intOut), 1);
    readAt('0, got);
    rawMode = 1'b0;
    btnDetect = '0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule